// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block runs the register sequence that keeps a CPU clock domain safe while the PLL feeding it is retuned. It accepts two requests, one issued before the PLL changes and one issued after. Each request carries the old and new PLL rates in kHz and the rate of the alternate clock source. A small table gives divider words for each supported rate. The block drives a simple register port into the clock controller: it reads and writes select and divider registers, and it polls their status registers.

In the pre phase the block first finds the table entry for the new rate. If the alternate source would run the CPU faster than the lower of the two PLL rates, it throttles the alternate source: it programs a safe divide value into a field of divider register 0 by read-modify-write. It then switches the CPU mux to the alternate source and waits for the mux status to confirm the switch. Next it writes divider register 0 and then divider register 1, and waits after each write until the divider status reads idle. In the post phase it returns the mux to the PLL, waits for confirmation, and clears the safe divide field.

Each status wait ends after a cycle limit derived from the clock frequency and a millisecond budget. When a wait expires the block records a timeout and carries on with the sequence. A busy output covers the whole sequence. A one-cycle done pulse closes it, and the error and warning flags stay readable until the next request is accepted.

Top module: `cpuclk_seq`

## Requirements
- R1: `busy` is high from the cycle after a request is accepted until the cycle `done` pulses. A pre or post request that arrives while busy is ignored and causes no register access. If both requests arrive together when idle, the pre request wins.
- R2: A table entry matches when its rate times 1000 equals `new_rate`. Entries are scanned from index 0, and a zero entry ends the scan. A pre request with no match, or a post request with no match while `cfg_dbg_div` is set, makes no register access, completes with `done`, and sets `err_nocfg`.
- R3: A pre request applies a safe divide only when `alt_rate > old_rate` or `old_rate > new_rate`. The value is ceil(alt_rate / min(old_rate, new_rate)) − 1. If that value reaches 8 or more, the block writes 7 and sets `warn_sat`.
- R4: The safe divide is written by reading divider register 0 (address 2) and changing only bits [2:0]. When `cfg_dbg_div` is set, bits [18:16] are also changed and are forced to 7 in the pre phase. All other bits keep their read value.
- R5: After any safe divide, the pre phase writes the select register (address 0) with bit 16 set to its read value. It waits until bits [18:16] of mux status (address 1) equal 2. It then writes the full table word to divider register 0 and waits until divider-0 status (address 3) reads zero. When `cfg_has_div1` is set, it then writes divider register 1 (address 4) and waits until divider-1 status (address 5) reads zero.
- R6: In a pre phase with `cfg_has_div1` set and bit 20 of the select register set, the block first reads divider register 1. The divider-1 word it writes keeps that read value in bits [6:4] and [2:0] and takes the table value everywhere else.
- R7: The post phase writes the select register with bit 16 cleared and waits for mux status bits [18:16] to equal 1. It then read-modify-writes divider register 0 with bits [2:0] set to 0. When `cfg_dbg_div` is set, it also sets bits [18:16] to the table entry's bits [18:16].
- R8: A status wait that is not satisfied within TIMEOUT_CYC cycles ends anyway. It sets `err_timeout`, and the sequence continues with its next step.
- R9: No register access is issued while the block is idle. Reads return data on `reg_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_req | input | 1 | Start pre-change sequence (one-cycle pulse) |
| post_req | input | 1 | Start post-change sequence (one-cycle pulse) |
| old_rate | input | RATE_W | Current PLL rate, kHz |
| new_rate | input | RATE_W | Target PLL rate, kHz |
| alt_rate | input | RATE_W | Alternate source rate, kHz |
| cfg_has_div1 | input | 1 | Divider register 1 present |
| cfg_dbg_div | input | 1 | Debug/trace divider field in divider register 0 must be managed |
| cfg_rate | input | NCFG*CRATE_W | Table rates in MHz units, entry 0 at the LSBs |
| cfg_div0 | input | NCFG*32 | Table divider-0 words |
| cfg_div1 | input | NCFG*32 | Table divider-1 words |
| reg_req | output | 1 | Register access strobe |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 3 | Register index (0 select, 1 mux status, 2 div0, 3 div0 status, 4 div1, 5 div1 status) |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nocfg | output | 1 | No table entry for the new rate |
| err_timeout | output | 1 | At least one status wait expired |
| warn_sat | output | 1 | Safe divide value saturated |

## Verification
The bench targets the throttling arithmetic at its edge. A ratio of exactly 8 must give 7 with no warning, while one kHz more must saturate and raise the warning; an off-by-one ceiling would flag a legal case or write a too-fast divider. It places a valid entry after a zero table entry, where a design that ignored the terminator would wrongly retune. It sets the monitor source bit, which a design without the merge would expose by overwriting the copy/monitor fields. It also checks that unrelated bits survive the read-modify-write. Stuck mux and divider status catch a design that hangs or skips the remaining writes after a timeout, and a request issued mid-sequence catches one that restarts while busy.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;

    localparam int FIELD_W   = 3;
    localparam int MAX_DIV   = 1 << FIELD_W;
    localparam int SEL_BIT   = 16;
    localparam int MON_BIT   = 20;
    localparam int MSTAT_LSB = 16;
    localparam int DBG_LSB   = 16;

    localparam logic [31:0] SAFE_MASK  = 32'(MAX_DIV - 1);
    localparam logic [31:0] DBG_MASK   = 32'(MAX_DIV - 1) << DBG_LSB;
    localparam logic [31:0] MON_FIELDS = 32'h0000_0077;
    localparam logic [31:0] MSTAT_MASK = 32'(7) << MSTAT_LSB;
    localparam logic [31:0] MST_ALT    = 32'(2) << MSTAT_LSB;
    localparam logic [31:0] MST_MAIN   = 32'(1) << MSTAT_LSB;

    localparam logic [2:0] A_SEL    = 3'd0;
    localparam logic [2:0] A_MSTAT  = 3'd1;
    localparam logic [2:0] A_DIV0   = 3'd2;
    localparam logic [2:0] A_DIV0ST = 3'd3;
    localparam logic [2:0] A_DIV1   = 3'd4;
    localparam logic [2:0] A_DIV1ST = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL_RD, S_SEL_CAP, S_D1_RD, S_D1_CAP, S_SAFE_RD,
        S_SAFE_WR, S_MUX_WR, S_D0_WR, S_D1_WR, S_POLL_RD, S_POLL_CHK, S_FIN
    } seq_state_e;

endpackage

// File: rtl/cpuclk_cfg_lookup.sv
module cpuclk_cfg_lookup #(
    parameter int NCFG    = 4,
    parameter int RATE_W  = 32,
    parameter int CRATE_W = 16
) (
    input  logic [RATE_W-1:0]       new_rate,
    input  logic [NCFG*CRATE_W-1:0] cfg_rate,
    input  logic [NCFG*32-1:0]      cfg_div0,
    input  logic [NCFG*32-1:0]      cfg_div1,
    output logic                    hit,
    output logic [31:0]             div0,
    output logic [31:0]             div1
);
    localparam int PW = CRATE_W + 10;
    localparam int CW = (PW > RATE_W) ? PW : RATE_W;

    logic               stop;
    logic [CRATE_W-1:0] ent;
    logic [CW-1:0]      prod;

    always_comb begin
        hit  = 1'b0;
        div0 = '0;
        div1 = '0;
        stop = 1'b0;
        ent  = '0;
        prod = '0;
        for (int i = 0; i < NCFG; i++) begin
            ent  = cfg_rate[i*CRATE_W +: CRATE_W];
            prod = CW'(ent) * CW'(1000);
            if (!stop) begin
                if (ent == '0) begin
                    stop = 1'b1;
                end else if (prod == CW'(new_rate)) begin
                    hit  = 1'b1;
                    div0 = cfg_div0[i*32 +: 32];
                    div1 = cfg_div1[i*32 +: 32];
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cpuclk_safe_div.sv
module cpuclk_safe_div
    import cpuclk_seq_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0]  alt_rate,
    input  logic [RATE_W-1:0]  old_rate,
    input  logic [RATE_W-1:0]  new_rate,
    output logic               need,
    output logic [FIELD_W-1:0] div,
    output logic               sat
);
    localparam int PW = RATE_W + FIELD_W + 1;

    logic [RATE_W-1:0] floor_rate;
    logic [PW-1:0]     prod;

    always_comb begin
        need       = (alt_rate > old_rate) || (old_rate > new_rate);
        floor_rate = (old_rate < new_rate) ? old_rate : new_rate;
        sat        = 1'b1;
        div        = '1;
        prod       = '0;
        for (int k = MAX_DIV; k >= 1; k--) begin
            prod = PW'(floor_rate) * PW'(k);
            if (floor_rate != '0 && prod >= PW'(alt_rate)) begin
                sat = 1'b0;
                div = FIELD_W'(k - 1);
            end
        end
    end

endmodule

// File: rtl/cpuclk_wait_timer.sv
module cpuclk_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)                   cnt_d = '0;
        else if (cnt_q == CW'(LIMIT)) cnt_d = cnt_q;
        else                        cnt_d = cnt_q + 1'b1;
        expired = (cnt_q == CW'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_timer_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

    assert_timer_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expired) |=> (cnt_q == $past(cnt_q) + 1'b1) || !$past(run));

endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq
    import cpuclk_seq_pkg::*;
#(
    parameter int NCFG       = 4,
    parameter int RATE_W     = 32,
    parameter int CRATE_W    = 16,
    parameter int CLK_KHZ    = 125000,
    parameter int TIMEOUT_MS = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pre_req,
    input  logic                    post_req,
    input  logic [RATE_W-1:0]       old_rate,
    input  logic [RATE_W-1:0]       new_rate,
    input  logic [RATE_W-1:0]       alt_rate,
    input  logic                    cfg_has_div1,
    input  logic                    cfg_dbg_div,
    input  logic [NCFG*CRATE_W-1:0] cfg_rate,
    input  logic [NCFG*32-1:0]      cfg_div0,
    input  logic [NCFG*32-1:0]      cfg_div1,
    output logic                    reg_req,
    output logic                    reg_we,
    output logic [2:0]              reg_addr,
    output logic [31:0]             reg_wdata,
    input  logic [31:0]             reg_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    err_nocfg,
    output logic                    err_timeout,
    output logic                    warn_sat
);
    localparam int TIMEOUT_CYC = CLK_KHZ * TIMEOUT_MS;

    typedef struct packed {
        seq_state_e  st;
        logic        pre;
        logic        has_d1;
        logic [31:0] sel;
        logic [31:0] tbl0;
        logic [31:0] tbl1;
        logic        safe_need;
        logic [31:0] safe_val;
        logic [31:0] safe_mask;
        logic [2:0]  paddr;
        logic [31:0] pmask;
        logic [31:0] pexp;
        seq_state_e  pnext;
        logic        done;
        logic        tmo;
        logic        nocfg;
        logic        warn;
    } seq_t;

    seq_t q, d;

    logic               lk_hit;
    logic [31:0]        lk_div0, lk_div1;
    logic               sd_need, sd_sat;
    logic [FIELD_W-1:0] sd_div;
    logic               poll_run, poll_exp;
    logic [31:0]        dbg_sel;

    cpuclk_cfg_lookup #(.NCFG(NCFG), .RATE_W(RATE_W), .CRATE_W(CRATE_W)) u_lookup (
        .new_rate (new_rate),
        .cfg_rate (cfg_rate),
        .cfg_div0 (cfg_div0),
        .cfg_div1 (cfg_div1),
        .hit      (lk_hit),
        .div0     (lk_div0),
        .div1     (lk_div1)
    );

    cpuclk_safe_div #(.RATE_W(RATE_W)) u_safe (
        .alt_rate (alt_rate),
        .old_rate (old_rate),
        .new_rate (new_rate),
        .need     (sd_need),
        .div      (sd_div),
        .sat      (sd_sat)
    );

    assign poll_run = (q.st == S_POLL_RD) || (q.st == S_POLL_CHK);

    cpuclk_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (poll_run),
        .expired (poll_exp)
    );

    assign dbg_sel = cfg_dbg_div ? DBG_MASK : 32'h0;

    // next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (pre_req || post_req) begin
                    d.pre       = pre_req;
                    d.has_d1    = cfg_has_div1;
                    d.tbl0      = lk_div0;
                    d.tbl1      = lk_div1;
                    d.tmo       = 1'b0;
                    d.safe_mask = SAFE_MASK | dbg_sel;
                    if (pre_req) begin
                        d.nocfg     = !lk_hit;
                        d.safe_need = sd_need;
                        d.warn      = lk_hit && sd_need && sd_sat;
                        d.safe_val  = 32'(sd_div) | dbg_sel;
                    end else begin
                        d.nocfg     = cfg_dbg_div && !lk_hit;
                        d.safe_need = 1'b1;
                        d.warn      = 1'b0;
                        d.safe_val  = lk_div0 & dbg_sel;
                    end
                    d.st = d.nocfg ? S_FIN : S_SEL_RD;
                end
            end
            S_SEL_RD:  d.st = S_SEL_CAP;
            S_SEL_CAP: begin
                d.sel = reg_rdata;
                if (q.pre && q.has_d1 && reg_rdata[MON_BIT]) d.st = S_D1_RD;
                else if (q.pre && q.safe_need)               d.st = S_SAFE_RD;
                else                                         d.st = S_MUX_WR;
            end
            S_D1_RD:   d.st = S_D1_CAP;
            S_D1_CAP: begin
                d.tbl1 = (q.tbl1 & ~MON_FIELDS) | (reg_rdata & MON_FIELDS);
                d.st   = q.safe_need ? S_SAFE_RD : S_MUX_WR;
            end
            S_SAFE_RD: d.st = S_SAFE_WR;
            S_SAFE_WR: begin
                d.paddr = A_DIV0ST;
                d.pmask = q.safe_mask;
                d.pexp  = '0;
                d.pnext = q.pre ? S_MUX_WR : S_FIN;
                d.st    = S_POLL_RD;
            end
            S_MUX_WR: begin
                d.paddr = A_MSTAT;
                d.pmask = MSTAT_MASK;
                d.pexp  = q.pre ? MST_ALT : MST_MAIN;
                d.pnext = q.pre ? S_D0_WR : S_SAFE_RD;
                d.st    = S_POLL_RD;
            end
            S_D0_WR: begin
                d.paddr = A_DIV0ST;
                d.pmask = '1;
                d.pexp  = '0;
                d.pnext = q.has_d1 ? S_D1_WR : S_FIN;
                d.st    = S_POLL_RD;
            end
            S_D1_WR: begin
                d.paddr = A_DIV1ST;
                d.pmask = '1;
                d.pexp  = '0;
                d.pnext = S_FIN;
                d.st    = S_POLL_RD;
            end
            S_POLL_RD: d.st = S_POLL_CHK;
            S_POLL_CHK: begin
                if ((reg_rdata & q.pmask) == q.pexp) begin
                    d.st = q.pnext;
                end else if (poll_exp) begin
                    d.tmo = 1'b1;
                    d.st  = q.pnext;
                end else begin
                    d.st = S_POLL_RD;
                end
            end
            S_FIN: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.pnext <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // register port, decoded from the current state
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = A_SEL;
        reg_wdata = '0;
        case (q.st)
            S_SEL_RD:  begin reg_req = 1'b1; reg_addr = A_SEL; end
            S_D1_RD:   begin reg_req = 1'b1; reg_addr = A_DIV1; end
            S_SAFE_RD: begin reg_req = 1'b1; reg_addr = A_DIV0; end
            S_POLL_RD: begin reg_req = 1'b1; reg_addr = q.paddr; end
            S_SAFE_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = A_DIV0;
                reg_wdata = (reg_rdata & ~q.safe_mask) | (q.safe_val & q.safe_mask);
            end
            S_MUX_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = A_SEL;
                reg_wdata = q.sel;
                reg_wdata[SEL_BIT] = q.pre;
            end
            S_D0_WR: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_DIV0; reg_wdata = q.tbl0;
            end
            S_D1_WR: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_DIV1; reg_wdata = q.tbl1;
            end
            default: ;
        endcase
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign err_nocfg   = q.nocfg;
    assign err_timeout = q.tmo;
    assign warn_sat    = q.warn;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_req);

    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_ignores_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.st != S_FIN) |=> (q.pre == $past(q.pre)));

    assert_miss_skips_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pre_req && !lk_hit) |=> (q.st == S_FIN && q.nocfg));

    assert_timeout_continues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_POLL_CHK && (reg_rdata & q.pmask) != q.pexp && poll_exp)
        |=> (q.tmo && q.st == $past(q.pnext)));

    // R3: a non-saturated safe value is the true ceiling quotient minus one
    always_ff @(posedge clk) begin
        if (rst_n && !sd_sat) begin
            assert_safe_ceiling_R3: assert (
                (64'(sd_div) + 64'd1) * 64'((old_rate < new_rate) ? old_rate : new_rate)
                    >= 64'(alt_rate) &&
                (sd_div == '0 ||
                 64'(sd_div) * 64'((old_rate < new_rate) ? old_rate : new_rate)
                    < 64'(alt_rate)));
        end
    end

endmodule

// File: tb/cpuclk_seq_bench.sv
module cpuclk_seq_bench;

    localparam int NCFG = 4;
    localparam int LIMIT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_req = 1'b0, post_req = 1'b0;
    logic [31:0] old_rate = '0, new_rate = '0, alt_rate = '0;
    logic        cfg_has_div1 = 1'b1, cfg_dbg_div = 1'b0;
    logic [NCFG*16-1:0] cfg_rate;
    logic [NCFG*32-1:0] cfg_div0, cfg_div1;
    logic        reg_req, reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        busy, done, err_nocfg, err_timeout, warn_sat;

    assign cfg_rate = {16'd500, 16'd0, 16'd1200, 16'd1400};
    assign cfg_div0 = {32'h0001_0001, 32'h0003_0003, 32'h0005_4121, 32'h0002_1235};
    assign cfg_div1 = {32'h0000_0111, 32'h0000_0222, 32'h0000_0213, 32'h0000_0345};

    always #4 clk = ~clk;

    cpuclk_seq #(.NCFG(NCFG), .CLK_KHZ(20), .TIMEOUT_MS(10)) u_cpuclk_seq (
        .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
        .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
        .cfg_has_div1(cfg_has_div1), .cfg_dbg_div(cfg_dbg_div),
        .cfg_rate(cfg_rate), .cfg_div0(cfg_div0), .cfg_div1(cfg_div1),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .err_nocfg(err_nocfg),
        .err_timeout(err_timeout), .warn_sat(warn_sat)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;

    // clock controller model
    logic [31:0] m_sel, m_div0, m_div1;
    int          mcnt, d0cnt, d1cnt;
    logic        stuck_mux = 1'b0, stuck_d0 = 1'b0;
    logic        poke = 1'b0;
    logic [31:0] poke_sel = '0;

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        logic [2:0] f;
        f = (stuck_mux || mcnt != 0) ? 3'd4 : (m_sel[16] ? 3'd2 : 3'd1);
        case (a)
            3'd0: return m_sel;
            3'd1: return {13'h0, f, 16'h0};
            3'd2: return m_div0;
            3'd3: return (stuck_d0 || d0cnt != 0) ? 32'h0007_0007 : 32'h0;
            3'd4: return m_div1;
            3'd5: return (d1cnt != 0) ? 32'h0000_0077 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel <= '0; m_div0 <= 32'hABC0_0006; m_div1 <= 32'h0000_7700;
            mcnt <= 0; d0cnt <= 0; d1cnt <= 0; reg_rdata <= '0;
        end else begin
            if (mcnt != 0)  mcnt  <= mcnt - 1;
            if (d0cnt != 0) d0cnt <= d0cnt - 1;
            if (d1cnt != 0) d1cnt <= d1cnt - 1;
            if (poke) m_sel <= poke_sel;
            if (reg_req && reg_we) begin
                case (reg_addr)
                    3'd0: begin m_sel  <= reg_wdata; mcnt  <= 3; end
                    3'd2: begin m_div0 <= reg_wdata; d0cnt <= 2; end
                    3'd4: begin m_div1 <= reg_wdata; d1cnt <= 2; end
                    default: ;
                endcase
            end else if (reg_req) begin
                reg_rdata <= model_rd(reg_addr);
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [2:0]  a;
        logic [31:0] d;
        string       tag;
    } wr_t;
    wr_t expq[$];

    task automatic push_wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        wr_t e;
        e.a = a; e.d = d; e.tag = tag;
        expq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && reg_req && reg_we) begin
            wr_t e;
            n_chk++;
            if (expq.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected write: actual addr %0d data %h expected none",
                         reg_addr, reg_wdata);
            end else begin
                e = expq.pop_front();
                if (e.a !== reg_addr || e.d !== reg_wdata) begin
                    n_fail++;
                    $display("FAIL %s write: actual addr %0d data %h expected addr %0d data %h",
                             e.tag, reg_addr, reg_wdata, e.a, e.d);
                end
            end
        end
        if (rst_n && done) n_done++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // independent reference of the table scan and safe divide
    function automatic bit ref_lookup(input logic [31:0] nr, output logic [31:0] t0,
                                      output logic [31:0] t1);
        t0 = '0; t1 = '0;
        for (int i = 0; i < NCFG; i++) begin
            logic [15:0] r;
            r = cfg_rate[i*16 +: 16];
            if (r == 0) return 1'b0;
            if (64'(r) * 64'd1000 == 64'(nr)) begin
                t0 = cfg_div0[i*32 +: 32];
                t1 = cfg_div1[i*32 +: 32];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    int last_cycles;

    task automatic do_seq(input bit pre, input logic [31:0] o, input logic [31:0] n,
                          input logic [31:0] a, input bit d1, input bit dbg,
                          input bit exp_tmo, input string tag);
        logic [31:0] t0, t1, mask, val, v1;
        logic [63:0] floor_r, qv;
        bit hit, need, sat, exp_nocfg, exp_warn;
        int cyc;
        hit = ref_lookup(n, t0, t1);
        mask = 32'h7 | (dbg ? 32'h0007_0000 : 32'h0);
        exp_warn = 1'b0;
        if (pre) begin
            exp_nocfg = !hit;
            need = (a > o) || (o > n);
            floor_r = (o < n) ? 64'(o) : 64'(n);
            qv = (64'(a) + floor_r - 1) / floor_r - 1;
            sat = (qv >= 8);
            if (sat) qv = 7;
            exp_warn = hit && need && sat;
            if (hit) begin
                if (need) begin
                    val = 32'(qv) | (dbg ? 32'h0007_0000 : 32'h0);
                    push_wr(3'd2, (m_div0 & ~mask) | (val & mask), "R3 R4 safe");
                end
                push_wr(3'd0, m_sel | 32'h0001_0000, "R5 mux");
                push_wr(3'd2, t0, "R5 div0");
                if (d1) begin
                    v1 = t1;
                    if (m_sel[20]) v1 = (t1 & ~32'h77) | (m_div1 & 32'h77);
                    push_wr(3'd4, v1, m_sel[20] ? "R6 div1 merge" : "R5 div1");
                end
            end
        end else begin
            exp_nocfg = dbg && !hit;
            if (!exp_nocfg) begin
                push_wr(3'd0, m_sel & ~32'h0001_0000, "R7 mux");
                val = dbg ? (t0 & 32'h0007_0000) : 32'h0;
                push_wr(3'd2, (m_div0 & ~mask) | (val & mask), "R7 safe clear");
            end
        end
        old_rate = o; new_rate = n; alt_rate = a;
        cfg_has_div1 = d1; cfg_dbg_div = dbg;
        if (pre) pre_req = 1'b1; else post_req = 1'b1;
        @(negedge clk);
        pre_req = 1'b0; post_req = 1'b0;
        check({tag, " R1 busy"}, 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        last_cycles = cyc;
        check({tag, " R1 done"}, 32'(done), 32'd1);
        check({tag, " R1 idle at done"}, 32'(busy), 32'd0);
        check({tag, " R2 nocfg"}, 32'(err_nocfg), 32'(exp_nocfg));
        check({tag, " R8 timeout"}, 32'(err_timeout), 32'(exp_tmo));
        check({tag, " R3 warn"}, 32'(warn_sat), 32'(exp_warn));
        @(negedge clk);
        check({tag, " all writes seen"}, 32'(expq.size()), 32'd0);
        expq.delete();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", 32'(busy), 32'd0);
        check("R9 reset req", 32'(reg_req), 32'd0);
        check("R9 reset flags", {29'h0, err_nocfg, err_timeout, warn_sat}, 32'd0);

        // upshift, no throttling, divider 1 present
        do_seq(1'b1, 32'd1200000, 32'd1400000, 32'd800000, 1'b1, 1'b0, 1'b0, "R5 up");
        do_seq(1'b0, 32'd1200000, 32'd1400000, 32'd800000, 1'b1, 1'b0, 1'b0, "R7 post");

        // downshift with debug field, monitor not from PLL
        poke_sel = 32'h0010_0000; poke = 1'b1;
        @(negedge clk); poke = 1'b0;
        do_seq(1'b1, 32'd1400000, 32'd1200000, 32'd800000, 1'b1, 1'b1, 1'b0, "R6 down");
        do_seq(1'b0, 32'd1400000, 32'd1200000, 32'd800000, 1'b1, 1'b1, 1'b0, "R7 dbg");

        // throttle: ratio 7.5 gives 7, no divider 1
        do_seq(1'b1, 32'd200000, 32'd1200000, 32'd1500000, 1'b0, 1'b0, 1'b0, "R3 ratio");
        // exact ratio 8 gives 7 without warning; one kHz more saturates
        do_seq(1'b1, 32'd100000, 32'd1400000, 32'd800000, 1'b1, 1'b0, 1'b0, "R3 edge");
        do_seq(1'b1, 32'd100000, 32'd1400000, 32'd800001, 1'b1, 1'b0, 1'b0, "R3 sat");

        // table misses: entry behind the zero terminator, and absent rate
        do_seq(1'b1, 32'd1200000, 32'd500000, 32'd800000, 1'b1, 1'b0, 1'b0, "R2 term");
        do_seq(1'b1, 32'd1200000, 32'd1000000, 32'd800000, 1'b1, 1'b0, 1'b0, "R2 miss");
        do_seq(1'b0, 32'd1200000, 32'd1000000, 32'd800000, 1'b1, 1'b1, 1'b0, "R2 post miss");

        // stuck mux status: timeout, sequence continues
        stuck_mux = 1'b1;
        do_seq(1'b1, 32'd1200000, 32'd1400000, 32'd800000, 1'b1, 1'b0, 1'b1, "R8 mux");
        check("R8 wait length", 32'(last_cycles >= LIMIT), 32'd1);
        stuck_mux = 1'b0;
        // stuck divider status in post phase
        stuck_d0 = 1'b1;
        do_seq(1'b0, 32'd1200000, 32'd1400000, 32'd800000, 1'b1, 1'b0, 1'b1, "R8 div0");
        stuck_d0 = 1'b0;

        // request while busy is ignored
        push_wr(3'd0, m_sel | 32'h0001_0000, "R1 mux");
        push_wr(3'd2, cfg_div0[31:0], "R1 div0");
        old_rate = 32'd1200000; new_rate = 32'd1400000; alt_rate = 32'd800000;
        cfg_has_div1 = 1'b0; cfg_dbg_div = 1'b0;
        dc = n_done;
        pre_req = 1'b1;
        @(negedge clk); pre_req = 1'b0;
        repeat (2) @(negedge clk);
        post_req = 1'b1;
        @(negedge clk); post_req = 1'b0;
        repeat (60) @(negedge clk);
        check("R1 ignored request: done count", 32'(n_done - dc), 32'd1);
        check("R1 ignored request: queue", 32'(expq.size()), 32'd0);
        check("R9 idle after", 32'(reg_req), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule